// File: doc/BRIEF.md
# Prioritised Nested Interrupt Controller

This block sits next to a CPU core and decides which interrupt the core should take next. It accepts a parameterised number of peripheral lines (32 by default) plus one non-maskable line. For each line it holds an enable bit, a pending bit and a 3-bit urgency level. It also holds a grouping setting that divides the level into a preempting part and a subpriority part, a masking threshold, and a global gate. The CPU sees a registered request, the index of the winning vector and a flag that shows whether taking it would nest on top of a running handler. The CPU answers with a one-cycle acknowledge when it enters a handler and a one-cycle return when it leaves one.

Software drives the controller through a small synchronous write/read port. The address is an operation code followed by a line index. A stack of active levels records the nesting. A handler can be interrupted only by a line whose group part is strictly more urgent than the group part of the level on top of the stack. The non-maskable line has its own active flag and does not go through the gate, the threshold or the level comparison.

Top module: `nested_irq_ctrl`

## Requirements
- R1: The register address is {op[2:0], line[5:0]}, with op codes 0 enable-set, 1 enable-clear, 2 pend-set, 3 pend-clear, 4 level field, 5 grouping, 6 mask threshold and 7 gate (bit 0, 1 = open). Read data is registered and appears the cycle after reg_rd. Ops 0/1 read the enable bit in bit 0 and ops 2/3 read the pending bit in bit 0. Line index 32 addresses the non-maskable line for ops 2/3.
- R2: After reset, cpu_req, cpu_vec and cpu_preempt are 0. All enable and pending bits, levels, grouping and mask are 0, and the gate is open (1).
- R3: A level write (op 4) keeps the top 3 bits of the 8-bit data. On read back the low 5 bits are zero (0xFF reads as 0xE0, 0x47 reads as 0x40).
- R4: Among eligible lines, the smallest level wins. On equal levels, the lowest line index wins.
- R5: A pending bit is set by a rising edge on irq_i or by a pend-set write. It stays set while the line is disabled. It can be read regardless of the enable bit. Enabling a pending line raises cpu_req with that line's index two cycles after the write.
- R6: An acknowledge (cpu_ack while cpu_req is high) clears the presented line's pending bit and pushes its level on the active stack. cpu_req is low in the cycle after the acknowledge.
- R7: A pend-clear write discards a pending request. The line is never presented afterwards.
- R8: A mask threshold of 0 blocks nothing. A threshold of N blocks every line whose level is N or above.
- R9: Grouping G (0 to 7) takes min(G,3) preempting bits from the top of the level. A line preempts only when its group part is strictly smaller than that of the top of the stack. G = 0 never preempts, and G = 7 behaves like G = 3.
- R10: A return pops one level from the stack. Lines that were blocked by the popped level may then be presented.
- R11: A closed gate keeps cpu_req low for peripheral lines and leaves every enable bit unchanged.
- R12: The non-maskable line is presented as vector 32 ahead of all other lines, regardless of gate, mask or nesting, until it is acknowledged. Pend-clear does not affect it. While its handler runs, no peripheral line is presented, and its return clears its active flag without popping the stack.
- R13: cpu_preempt is high exactly when a request is presented while at least one handler is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous active-high reset |
| irq_i | input | NUM_LINES | Peripheral interrupt sources, rising-edge sensitive |
| nmi_i | input | 1 | Non-maskable source, rising-edge sensitive |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | LW+3 | {op, line index} |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| cpu_ack | input | 1 | CPU enters the presented handler |
| cpu_ret | input | 1 | CPU leaves the current handler |
| cpu_req | output | 1 | Interrupt request to the CPU |
| cpu_vec | output | LW | Winning vector index (32 = non-maskable) |
| cpu_preempt | output | 1 | Request would nest on an active handler |

## Verification
A corrupted pending bit shows up two cycles later: either a vector is presented that software has already discarded or the CPU has already taken, or a line that software pended and enabled is silently missing. A wrong entry or count in the active stack changes which lines may preempt. The error appears on cpu_req and cpu_preempt as soon as the next candidate is pended or the next return is issued. A bad grouping mask or threshold appears as the wrong vector winning when two lines are pending at once, so the scenarios always pair lines whose ordering depends on the setting under test.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int FIELD_W = 8;
  localparam int GRP_W   = 3;

  typedef enum logic [2:0] {
    OP_ENA_SET = 3'd0,
    OP_ENA_CLR = 3'd1,
    OP_PND_SET = 3'd2,
    OP_PND_CLR = 3'd3,
    OP_PRIO    = 3'd4,
    OP_GROUP   = 3'd5,
    OP_MASK    = 3'd6,
    OP_GATE    = 3'd7
  } icu_op_e;
endpackage

// File: rtl/icu_cfg.sv
module icu_cfg
  import icu_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int PRIO_BITS = 3,
  parameter int LW        = 6
) (
  input  logic                 clk,
  input  logic                 srst,
  input  logic                 wr,
  input  logic                 rd,
  input  icu_op_e              op,
  input  logic [LW-1:0]        idx,
  input  logic [FIELD_W-1:0]   wdata,
  input  logic [NUM_LINES-1:0] pend,
  input  logic                 nmi_pend,
  output logic [NUM_LINES-1:0] en,
  output logic [PRIO_BITS-1:0] prio [NUM_LINES],
  output logic [GRP_W-1:0]     grouping,
  output logic [PRIO_BITS-1:0] mask,
  output logic                 gate,
  output logic [FIELD_W-1:0]   rdata
);
  localparam int LOW_W = FIELD_W - PRIO_BITS;

  logic [FIELD_W-1:0] rd_mux;
  logic               unused_wdata;
  assign unused_wdata = ^wdata;

  // read multiplexer
  always_comb begin
    rd_mux = '0;
    case (op)
      OP_ENA_SET, OP_ENA_CLR:
        for (int i = 0; i < NUM_LINES; i++)
          if (idx == LW'(i)) rd_mux[0] = en[i];
      OP_PND_SET, OP_PND_CLR: begin
        for (int i = 0; i < NUM_LINES; i++)
          if (idx == LW'(i)) rd_mux[0] = pend[i];
        if (idx == LW'(NUM_LINES)) rd_mux[0] = nmi_pend;
      end
      OP_PRIO:
        for (int i = 0; i < NUM_LINES; i++)
          if (idx == LW'(i)) rd_mux = {prio[i], {LOW_W{1'b0}}};
      OP_GROUP: rd_mux = FIELD_W'(grouping);
      OP_MASK:  rd_mux = FIELD_W'(mask);
      OP_GATE:  rd_mux = FIELD_W'(gate);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      en       <= '0;
      grouping <= '0;
      mask     <= '0;
      gate     <= 1'b1;
      rdata    <= '0;
      for (int i = 0; i < NUM_LINES; i++) prio[i] <= '0;
    end else begin
      if (rd) rdata <= rd_mux;
      if (wr) begin
        case (op)
          OP_ENA_SET, OP_ENA_CLR:
            for (int i = 0; i < NUM_LINES; i++)
              if (idx == LW'(i)) en[i] <= (op == OP_ENA_SET);
          OP_PRIO:
            for (int i = 0; i < NUM_LINES; i++)
              if (idx == LW'(i)) prio[i] <= wdata[FIELD_W-1 -: PRIO_BITS];
          OP_GROUP: grouping <= wdata[GRP_W-1:0];
          OP_MASK:  mask     <= wdata[PRIO_BITS-1:0];
          OP_GATE:  gate     <= wdata[0];
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/icu_pend.sv
module icu_pend #(
  parameter int NUM_LINES = 32,
  parameter int LW        = 6
) (
  input  logic                 clk,
  input  logic                 srst,
  input  logic [NUM_LINES-1:0] irq,
  input  logic                 nmi,
  input  logic                 sw_set,
  input  logic                 sw_clr,
  input  logic [LW-1:0]        idx,
  input  logic                 take,
  input  logic [LW-1:0]        take_vec,
  output logic [NUM_LINES-1:0] pend,
  output logic                 nmi_pend
);
  logic [NUM_LINES-1:0] irq_prev;
  logic                 nmi_prev;

  always_ff @(posedge clk) begin
    if (srst) begin
      irq_prev <= '0;
      nmi_prev <= 1'b0;
    end else begin
      irq_prev <= irq;
      nmi_prev <= nmi;
    end
  end

  // one pending flop per line; a set in the same cycle as a clear wins
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic set_g, clr_g;
    assign set_g = (irq[g] & ~irq_prev[g]) | (sw_set && idx == LW'(g));
    assign clr_g = (sw_clr && idx == LW'(g)) | (take && take_vec == LW'(g));
    always_ff @(posedge clk) begin
      if (srst) pend[g] <= 1'b0;
      else      pend[g] <= (pend[g] & ~clr_g) | set_g;
    end
  end

  // non-maskable: software cannot clear it, only entry into its handler
  logic nmi_set, nmi_clr;
  assign nmi_set = (nmi & ~nmi_prev) | (sw_set && idx == LW'(NUM_LINES));
  assign nmi_clr = take && take_vec == LW'(NUM_LINES);

  always_ff @(posedge clk) begin
    if (srst) nmi_pend <= 1'b0;
    else      nmi_pend <= (nmi_pend & ~nmi_clr) | nmi_set;
  end
endmodule

// File: rtl/icu_arb.sv
module icu_arb #(
  parameter int NUM_LINES = 32,
  parameter int PRIO_BITS = 3,
  parameter int LW        = 6
) (
  input  logic [NUM_LINES-1:0] pend,
  input  logic [NUM_LINES-1:0] en,
  input  logic [PRIO_BITS-1:0] prio [NUM_LINES],
  input  logic [PRIO_BITS-1:0] mask,
  input  logic [PRIO_BITS-1:0] gmask,
  input  logic                 act_valid,
  input  logic [PRIO_BITS-1:0] act_grp,
  output logic                 found,
  output logic [LW-1:0]        win_idx
);
  logic [PRIO_BITS-1:0] win_lvl;
  logic                 elig;

  // linear scan: strict compare keeps the lowest index on ties
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '1;
    elig    = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      elig = pend[i] && en[i]
          && (mask == '0 || prio[i] < mask)
          && (!act_valid || (prio[i] & gmask) < act_grp);
      if (elig && (!found || prio[i] < win_lvl)) begin
        found   = 1'b1;
        win_idx = LW'(i);
        win_lvl = prio[i];
      end
    end
  end
endmodule

// File: rtl/icu_stack.sv
module icu_stack #(
  parameter int PRIO_BITS = 3,
  parameter int DEPTH     = 8,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 srst,
  input  logic                 push,
  input  logic [PRIO_BITS-1:0] push_lvl,
  input  logic                 pop,
  output logic [PRIO_BITS-1:0] top_lvl,
  output logic [CW-1:0]        cnt
);
  logic [PRIO_BITS-1:0] mem [DEPTH];

  always_comb begin
    top_lvl = '0;
    for (int i = 0; i < DEPTH; i++)
      if (cnt == CW'(i + 1)) top_lvl = mem[i];
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push && pop) begin
      for (int i = 0; i < DEPTH; i++)
        if (cnt == CW'(i + 1)) mem[i] <= push_lvl;
    end else if (push && cnt != CW'(DEPTH)) begin
      for (int i = 0; i < DEPTH; i++)
        if (cnt == CW'(i)) mem[i] <= push_lvl;
      cnt <= cnt + 1'b1;
    end else if (pop && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
  import icu_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int PRIO_BITS = 3,
  localparam int LW       = $clog2(NUM_LINES + 1),
  localparam int AW       = LW + 3
) (
  input  logic                 clk,
  input  logic                 srst,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic                 nmi_i,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [AW-1:0]        reg_addr,
  input  logic [FIELD_W-1:0]   reg_wdata,
  output logic [FIELD_W-1:0]   reg_rdata,
  input  logic                 cpu_ack,
  input  logic                 cpu_ret,
  output logic                 cpu_req,
  output logic [LW-1:0]        cpu_vec,
  output logic                 cpu_preempt
);
  localparam int DEPTH = 1 << PRIO_BITS;
  localparam int CW    = $clog2(DEPTH + 1);

  icu_op_e              op;
  logic [LW-1:0]        idx;
  logic [NUM_LINES-1:0] en, pend;
  logic [PRIO_BITS-1:0] prio [NUM_LINES];
  logic [GRP_W-1:0]     grouping;
  logic [PRIO_BITS-1:0] mask, gmask, top_lvl, act_grp, take_lvl;
  logic                 gate_q, nmi_pend, nmi_act;
  logic [CW-1:0]        stk_cnt;
  logic                 found, take, vec_is_nmi, stk_nonempty;
  logic [LW-1:0]        win_idx;
  logic                 req_q, preempt_q;
  logic [LW-1:0]        vec_q;
  logic                 nmi_req, req_next;

  assign op  = icu_op_e'(reg_addr[AW-1 -: 3]);
  assign idx = reg_addr[LW-1:0];

  icu_cfg #(.NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS), .LW(LW)) u_cfg (
    .clk(clk), .srst(srst), .wr(reg_wr), .rd(reg_rd), .op(op), .idx(idx),
    .wdata(reg_wdata), .pend(pend), .nmi_pend(nmi_pend), .en(en), .prio(prio),
    .grouping(grouping), .mask(mask), .gate(gate_q), .rdata(reg_rdata)
  );

  assign take       = cpu_ack && req_q;
  assign vec_is_nmi = (vec_q == LW'(NUM_LINES));

  icu_pend #(.NUM_LINES(NUM_LINES), .LW(LW)) u_pend (
    .clk(clk), .srst(srst), .irq(irq_i), .nmi(nmi_i),
    .sw_set(reg_wr && op == OP_PND_SET), .sw_clr(reg_wr && op == OP_PND_CLR),
    .idx(idx), .take(take), .take_vec(vec_q), .pend(pend), .nmi_pend(nmi_pend)
  );

  // level of the line being entered
  always_comb begin
    take_lvl = '0;
    for (int i = 0; i < NUM_LINES; i++)
      if (vec_q == LW'(i)) take_lvl = prio[i];
  end

  icu_stack #(.PRIO_BITS(PRIO_BITS), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .srst(srst), .push(take && !vec_is_nmi), .push_lvl(take_lvl),
    .pop(cpu_ret && !nmi_act), .top_lvl(top_lvl), .cnt(stk_cnt)
  );

  assign stk_nonempty = (stk_cnt != '0);

  // preempting bits sit at the top of the level
  always_comb begin
    int gsel;
    gsel  = (int'(grouping) > PRIO_BITS) ? PRIO_BITS : int'(grouping);
    gmask = '0;
    for (int j = 0; j < PRIO_BITS; j++)
      gmask[j] = (j >= PRIO_BITS - gsel);
  end

  assign act_grp = top_lvl & gmask;

  icu_arb #(.NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS), .LW(LW)) u_arb (
    .pend(pend), .en(en), .prio(prio), .mask(mask), .gmask(gmask),
    .act_valid(stk_nonempty), .act_grp(act_grp), .found(found), .win_idx(win_idx)
  );

  always_ff @(posedge clk) begin
    if (srst)                       nmi_act <= 1'b0;
    else if (take && vec_is_nmi)    nmi_act <= 1'b1;
    else if (cpu_ret && nmi_act)    nmi_act <= 1'b0;
  end

  assign nmi_req  = nmi_pend && !nmi_act;
  assign req_next = !take && (nmi_req || (found && gate_q && !nmi_act));

  always_ff @(posedge clk) begin
    if (srst) begin
      req_q     <= 1'b0;
      vec_q     <= '0;
      preempt_q <= 1'b0;
    end else begin
      req_q     <= req_next;
      vec_q     <= !req_next ? '0 : (nmi_req ? LW'(NUM_LINES) : win_idx);
      preempt_q <= req_next && stk_nonempty;
    end
  end

  assign cpu_req     = req_q;
  assign cpu_vec     = vec_q;
  assign cpu_preempt = preempt_q;
endmodule

// File: rtl/icu_chk.sv
module icu_chk #(
  parameter int NUM_LINES = 32,
  parameter int LW        = 6,
  parameter int DEPTH     = 8,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          srst,
  input logic          cpu_ack,
  input logic          cpu_req,
  input logic [LW-1:0] cpu_vec,
  input logic          cpu_preempt,
  input logic          gate,
  input logic          nmi_pend,
  input logic          nmi_act,
  input logic [CW-1:0] cnt
);
  // R6: an accepted acknowledge drops the request for one cycle
  a_r6_ack_drops_req: assert property (@(posedge clk) disable iff (srst)
    (cpu_ack && cpu_req) |=> !cpu_req);

  // R13: the nesting flag never stands without a request
  a_r13_preempt_needs_req: assert property (@(posedge clk) disable iff (srst)
    cpu_preempt |-> cpu_req);

  // R11: a peripheral vector is only presented through an open gate
  a_r11_gate_blocks: assert property (@(posedge clk) disable iff (srst)
    (cpu_req && cpu_vec != LW'(NUM_LINES)) |-> $past(gate));

  // R12: a pending, idle non-maskable line is always the presented vector
  a_r12_nmi_wins: assert property (@(posedge clk) disable iff (srst)
    $past(nmi_pend && !nmi_act && !(cpu_ack && cpu_req))
      |-> (cpu_req && cpu_vec == LW'(NUM_LINES)));

  // R10: the active stack stays within its depth
  a_r10_stack_bounded: assert property (@(posedge clk) disable iff (srst)
    cnt <= CW'(DEPTH));
endmodule

bind nested_irq_ctrl icu_chk #(.NUM_LINES(NUM_LINES), .LW(LW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .srst(srst), .cpu_ack(cpu_ack), .cpu_req(cpu_req), .cpu_vec(cpu_vec),
  .cpu_preempt(cpu_preempt), .gate(gate_q), .nmi_pend(nmi_pend),
  .nmi_act(nmi_act), .cnt(stk_cnt)
);

// File: tb/tb_nested_irq_ctrl.sv
module tb_nested_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 32;
  localparam int NMI = 32;

  localparam logic [2:0] ENA_SET = 3'd0, ENA_CLR = 3'd1, PND_SET = 3'd2, PND_CLR = 3'd3,
                         PRIO = 3'd4, GROUP = 3'd5, MASK = 3'd6, GATE = 3'd7;

  logic        clk = 1'b0;
  logic        srst = 1'b1;
  logic [N-1:0] irq_i = '0;
  logic        nmi_i = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        cpu_ack = 1'b0, cpu_ret = 1'b0;
  logic        cpu_req;
  logic [5:0]  cpu_vec;
  logic        cpu_preempt;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nested_irq_ctrl dut (
    .clk(clk), .srst(srst), .irq_i(irq_i), .nmi_i(nmi_i), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_ack(cpu_ack), .cpu_ret(cpu_ret), .cpu_req(cpu_req), .cpu_vec(cpu_vec),
    .cpu_preempt(cpu_preempt)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] op, int line, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = {op, 6'(line)}; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] op, int line, output logic [7:0] v);
    reg_rd = 1'b1; reg_addr = {op, 6'(line)};
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic ack();
    cpu_ack = 1'b1;
    @(negedge clk);
    cpu_ack = 1'b0;
  endtask

  task automatic ret();
    cpu_ret = 1'b1;
    @(negedge clk);
    cpu_ret = 1'b0;
  endtask

  task automatic do_reset();
    srst = 1'b1;
    tick(3);
    srst = 1'b0;
    tick(1);
  endtask

  task automatic expect_req(string tag, int r, int v, int p);
    chk({tag, " req"}, int'(cpu_req), r);
    chk({tag, " vec"}, int'(cpu_vec), v);
    chk({tag, " preempt"}, int'(cpu_preempt), p);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    expect_req("R2 reset", 0, 0, 0);
    rd(GATE, 0, v);  chk("R2 R1 gate reset open", int'(v), 1);
    rd(GROUP, 0, v); chk("R2 grouping reset", int'(v), 0);
    rd(MASK, 0, v);  chk("R2 mask reset", int'(v), 0);
    rd(ENA_SET, 9, v); chk("R2 enable reset", int'(v), 0);
  endtask

  task automatic t_prio_field();
    logic [7:0] v;
    do_reset();
    wr(PRIO, 5, 8'hFF); rd(PRIO, 5, v); chk("R3 0xFF reads 0xE0", int'(v), 8'hE0);
    wr(PRIO, 5, 8'h47); rd(PRIO, 5, v); chk("R3 0x47 reads 0x40", int'(v), 8'h40);
  endtask

  task automatic t_pending();
    logic [7:0] v;
    do_reset();
    irq_i[3] = 1'b1; tick(2); irq_i[3] = 1'b0; tick(2);
    expect_req("R5 disabled line silent", 0, 0, 0);
    rd(PND_SET, 3, v); chk("R5 R1 pending visible while disabled", int'(v), 1);
    wr(ENA_SET, 3, 8'h00); tick(2);
    expect_req("R5 enabled line presented", 1, 3, 0);
    ack();
    chk("R6 req low after ack", int'(cpu_req), 0);
    rd(PND_CLR, 3, v); chk("R6 pending cleared on ack", int'(v), 0);
    tick(2);
    chk("R6 no re-request", int'(cpu_req), 0);
    ret(); tick(2);
    chk("R10 idle after return", int'(cpu_req), 0);
  endtask

  task automatic t_select();
    do_reset();
    wr(PRIO, 2, 8'h60); wr(PRIO, 7, 8'h20); wr(PRIO, 9, 8'h20);
    wr(ENA_SET, 2, 0); wr(ENA_SET, 7, 0); wr(ENA_SET, 9, 0);
    wr(PND_SET, 9, 0); wr(PND_SET, 2, 0); wr(PND_SET, 7, 0);
    tick(2);
    expect_req("R4 lowest level, lowest index", 1, 7, 0);
    ack(); tick(2);
    chk("R9 grouping 0 never preempts", int'(cpu_req), 0);
    ret(); tick(2);
    expect_req("R10 R4 tie goes to next index", 1, 9, 0);
    ack(); ret(); tick(2);
    expect_req("R4 remaining line", 1, 2, 0);
  endtask

  task automatic t_unpend();
    logic [7:0] v;
    do_reset();
    wr(ENA_SET, 4, 0); wr(PND_SET, 4, 0); tick(2);
    expect_req("R7 pended line", 1, 4, 0);
    wr(PND_CLR, 4, 0); tick(2);
    chk("R7 discarded request", int'(cpu_req), 0);
    rd(PND_SET, 4, v); chk("R7 pending bit zero", int'(v), 0);
  endtask

  task automatic t_mask();
    do_reset();
    wr(PRIO, 1, 8'h80); wr(PRIO, 6, 8'h40);
    wr(ENA_SET, 1, 0); wr(ENA_SET, 6, 0);
    wr(PND_SET, 1, 0); wr(PND_SET, 6, 0);
    wr(MASK, 0, 8'd2); tick(2);
    chk("R8 threshold 2 blocks levels 2 and 4", int'(cpu_req), 0);
    wr(MASK, 0, 8'd3); tick(2);
    expect_req("R8 threshold 3 passes level 2", 1, 6, 0);
    wr(PND_CLR, 6, 0); tick(2);
    chk("R8 threshold 3 blocks level 4", int'(cpu_req), 0);
    wr(MASK, 0, 8'd5); tick(2);
    expect_req("R8 threshold 5 passes level 4", 1, 1, 0);
    wr(MASK, 0, 8'd0); tick(2);
    expect_req("R8 threshold 0 passes all", 1, 1, 0);
  endtask

  task automatic t_group();
    do_reset();
    wr(GROUP, 0, 8'd2);
    wr(PRIO, 10, 8'h80); wr(PRIO, 11, 8'h60); wr(PRIO, 12, 8'h40);
    wr(ENA_SET, 10, 0); wr(ENA_SET, 11, 0); wr(ENA_SET, 12, 0);
    wr(PND_SET, 10, 0); tick(2);
    expect_req("R9 first handler", 1, 10, 0);
    ack();
    wr(PND_SET, 12, 0); tick(2);
    expect_req("R9 R13 stricter group preempts", 1, 12, 1);
    ack();
    wr(PND_SET, 11, 0); tick(2);
    chk("R9 equal group does not preempt", int'(cpu_req), 0);
    ret(); tick(2);
    expect_req("R10 pop exposes blocked line", 1, 11, 1);
    ack(); ret(); ret(); tick(2);
    chk("R10 all handlers left", int'(cpu_req), 0);
    wr(PRIO, 13, 8'hA0); wr(PRIO, 14, 8'h80);
    wr(ENA_SET, 13, 0); wr(ENA_SET, 14, 0);
    wr(PND_SET, 13, 0); tick(2);
    ack();
    wr(PND_SET, 14, 0); tick(2);
    chk("R9 grouping 2 masks low bit", int'(cpu_req), 0);
    wr(GROUP, 0, 8'd7); tick(2);
    expect_req("R9 grouping 7 acts as 3", 1, 14, 1);
  endtask

  task automatic t_gate_nmi();
    logic [7:0] v;
    do_reset();
    wr(ENA_SET, 15, 0); wr(PND_SET, 15, 0);
    wr(GATE, 0, 8'd0); tick(2);
    chk("R11 closed gate blocks", int'(cpu_req), 0);
    rd(ENA_SET, 15, v); chk("R11 enable unchanged", int'(v), 1);
    nmi_i = 1'b1; tick(1); nmi_i = 1'b0; tick(2);
    expect_req("R12 nmi through closed gate", 1, NMI, 0);
    wr(PND_CLR, NMI, 0); tick(2);
    expect_req("R12 nmi unpend ignored", 1, NMI, 0);
    rd(PND_SET, NMI, v); chk("R12 R1 nmi still pending", int'(v), 1);
    ack();
    wr(GATE, 0, 8'd1); tick(2);
    chk("R12 no peripheral during nmi handler", int'(cpu_req), 0);
    ret(); tick(2);
    expect_req("R12 stack untouched by nmi return", 1, 15, 0);
    ack();
    wr(PND_SET, NMI, 0); tick(2);
    expect_req("R12 R13 nmi preempts handler", 1, NMI, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_prio_field();
    t_pending();
    t_select();
    t_unpend();
    t_mask();
    t_group();
    t_gate_nmi();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule